// File: doc/BRIEF.md
# Crypto Mode Lock Tracker

This block watches the crypto-mode selection that feeds one ingress crypto path, either the encrypt side or the decrypt side. It samples the selection in every clock cycle. Stream valid, lane-enable and start-of-packet qualifiers play no part, so the block has no such inputs. For each tracked entry it records the first legal mode it sees after reset or after a flush. It then reports any later attempt to select a different mode before that entry is flushed again.

The block works in one of two configurations, chosen by a static pin. In fixed-port configuration, each of `NUM_PORTS` ports has its own mode slot and its own lock. In channelized configuration, only slot 0 of the mode input is used. It applies to the channel named by the stream channel ID in that same cycle, and each of `NUM_CH` channels keeps its own lock. A flush comes from either of two sources. One is a per-entry register bit. The other is the stream-side flush input: in fixed-port configuration it has one bit per port, and in channelized configuration its bit 0 flushes the channel currently named by the ID.

The block moves no data, so it has no valid/ready handshake and applies no back-pressure. Every input is plain and is read on each rising edge. Every output is registered and shows the effect of the inputs of edge N right after edge N.

Top module: `crypto_mode_lock`

## Requirements
- R1: While reset is held, and right after it, every lock-valid bit is 0 and both the violation pulse and the illegal pulse are 0.
- R2: Mode codes are 3 bits: 0 bypass, 1 whole-buffer cipher, 2 block-wise cipher without chaining, 3 link-layer security, 4 network-layer security. In fixed-port configuration (channelized pin 0), port p reads bits [3p+2:3p] of the mode input in every cycle. The first legal code after reset or flush is shown as locked, valid and with that mode, after the next edge.
- R3: In channelized configuration (pin 1), mode-input bits [2:0] apply only to the channel whose index equals the channel ID. No other channel's lock changes because of that sample.
- R4: If an unflushed entry is locked and samples a legal code that differs from its lock, the violation pulse is 1 for one cycle after that edge, with the entry index on the channel output. The locked mode does not change.
- R5: When several entries violate at the same edge, the reported index is the lowest of them.
- R6: A sampled code of 5, 6 or 7 gives a one-cycle illegal pulse after the edge. It is never latched and it never causes a violation.
- R7: Register flush bit c clears entry c's lock at that edge, in either configuration, unless the same entry samples a legal code in that cycle (see R9).
- R8: In fixed-port configuration, stream flush bit p flushes port p. In channelized configuration, stream flush bit 0 flushes the channel named by the ID, and bits 1 and up have no effect.
- R9: If a flush and a legal sample reach the same entry in one cycle, the flush is applied first. The sampled code becomes that entry's lock, and no violation is raised.
- R10: In channelized configuration, a channel ID of NUM_CH or more selects no entry. Neither its mode sample nor its stream flush changes any lock or raises any pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_cfg | input | 1 | 1 = channelized, 0 = fixed-port; static |
| mode_in | input | NUM_PORTS*3 | Per-port mode slots; slot 0 is shared in channelized |
| chan_id | input | CH_W | Stream channel ID |
| strm_flush | input | NUM_PORTS | Stream-side flush bits |
| reg_flush | input | NUM_CH | Per-entry register flush bits |
| lock_valid | output | NUM_CH | Entry holds a lock |
| lock_mode | output | NUM_CH*3 | Locked code per entry, 3 bits each |
| viol_pulse | output | 1 | Mode change attempted on a locked entry |
| viol_ch | output | CH_W | Lowest violating entry index |
| illegal_pulse | output | 1 | Code 5 to 7 was sampled |

## Verification
The bench builds the block with NUM_CH = 6 and NUM_PORTS = 4, so CH_W is 3. This makes channel IDs 6 and 7 legal on the wire but out of range, which exercises the ignore path of R10. The small channel count also lets directed loops lock, violate and flush every channel, and lets a random phase revisit every channel many times. Four ports keep the fixed-port lowest-index priority and the per-port stream flush reachable alongside the channel entries that fixed-port configuration never samples.

// File: rtl/cml_pkg.sv
package cml_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_BYPASS = 3'd0,
    MODE_BULK   = 3'd1,
    MODE_ECB    = 3'd2,
    MODE_LINK   = 3'd3,
    MODE_NET    = 3'd4
  } crypto_mode_e;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return m <= MODE_NET;
  endfunction
endpackage

// File: rtl/cml_route.sv
module cml_route
  import cml_pkg::*;
#(
  parameter int NUM_CH    = 40,
  parameter int NUM_PORTS = 4,
  parameter int CH_W      = 6
) (
  input  logic                        chan_cfg,
  input  logic [NUM_PORTS*MODE_W-1:0] mode_in,
  input  logic [CH_W-1:0]             chan_id,
  input  logic [NUM_PORTS-1:0]        strm_flush,
  input  logic [NUM_CH-1:0]           reg_flush,
  output logic [NUM_CH-1:0]           samp_en,
  output logic [NUM_CH*MODE_W-1:0]    samp_mode,
  output logic [NUM_CH-1:0]           flush
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ent
    localparam logic [CH_W-1:0] IDX = CH_W'(c);
    logic hit;
    logic fix_en;
    logic fix_fl;
    logic [MODE_W-1:0] fix_mode;

    assign hit = (chan_id == IDX);

    if (c < NUM_PORTS) begin : g_port
      assign fix_en   = 1'b1;
      assign fix_mode = mode_in[c*MODE_W +: MODE_W];
      assign fix_fl   = reg_flush[c] | strm_flush[c];
    end else begin : g_noport
      assign fix_en   = 1'b0;
      assign fix_mode = '0;
      assign fix_fl   = reg_flush[c];
    end

    assign samp_en[c]                     = chan_cfg ? hit : fix_en;
    assign samp_mode[c*MODE_W +: MODE_W]  = chan_cfg ? mode_in[MODE_W-1:0] : fix_mode;
    assign flush[c] = chan_cfg ? (reg_flush[c] | (strm_flush[0] & hit)) : fix_fl;
  end
endmodule

// File: rtl/cml_entry.sv
module cml_entry
  import cml_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic [MODE_W-1:0] samp_mode,
  input  logic              flush,
  output logic              valid,
  output logic [MODE_W-1:0] mode,
  output logic              viol,
  output logic              illegal
);
  logic legal;
  logic take;

  assign legal   = mode_legal(samp_mode);
  assign take    = samp_en & legal & (flush | ~valid);
  assign illegal = samp_en & ~legal;
  assign viol    = samp_en & legal & valid & ~flush & (samp_mode != mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      mode  <= MODE_BYPASS;
    end else if (take) begin
      valid <= 1'b1;
      mode  <= samp_mode;
    end else if (flush) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cml_report.sv
module cml_report #(
  parameter int NUM_CH = 40,
  parameter int CH_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] viol,
  input  logic [NUM_CH-1:0] illegal,
  output logic              viol_pulse,
  output logic [CH_W-1:0]   viol_ch,
  output logic              illegal_pulse
);
  logic [CH_W-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (viol[i]) low_idx = CH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_pulse    <= 1'b0;
      viol_ch       <= '0;
      illegal_pulse <= 1'b0;
    end else begin
      viol_pulse    <= |viol;
      viol_ch       <= (|viol) ? low_idx : '0;
      illegal_pulse <= |illegal;
    end
  end
endmodule

// File: rtl/crypto_mode_lock.sv
module crypto_mode_lock
  import cml_pkg::*;
#(
  parameter int NUM_CH    = 40,
  parameter int NUM_PORTS = 4,
  parameter int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        chan_cfg,
  input  logic [NUM_PORTS*MODE_W-1:0] mode_in,
  input  logic [CH_W-1:0]             chan_id,
  input  logic [NUM_PORTS-1:0]        strm_flush,
  input  logic [NUM_CH-1:0]           reg_flush,
  output logic [NUM_CH-1:0]           lock_valid,
  output logic [NUM_CH*MODE_W-1:0]    lock_mode,
  output logic                        viol_pulse,
  output logic [CH_W-1:0]             viol_ch,
  output logic                        illegal_pulse
);
  logic [NUM_CH-1:0]        samp_en;
  logic [NUM_CH*MODE_W-1:0] samp_mode;
  logic [NUM_CH-1:0]        flush;
  logic [NUM_CH-1:0]        viol;
  logic [NUM_CH-1:0]        illegal;

  cml_route #(.NUM_CH(NUM_CH), .NUM_PORTS(NUM_PORTS), .CH_W(CH_W)) u_route (
    .chan_cfg   (chan_cfg),
    .mode_in    (mode_in),
    .chan_id    (chan_id),
    .strm_flush (strm_flush),
    .reg_flush  (reg_flush),
    .samp_en    (samp_en),
    .samp_mode  (samp_mode),
    .flush      (flush)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lock
    cml_entry u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_en   (samp_en[c]),
      .samp_mode (samp_mode[c*MODE_W +: MODE_W]),
      .flush     (flush[c]),
      .valid     (lock_valid[c]),
      .mode      (lock_mode[c*MODE_W +: MODE_W]),
      .viol      (viol[c]),
      .illegal   (illegal[c])
    );
  end

  cml_report #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_report (
    .clk           (clk),
    .rst_n         (rst_n),
    .viol          (viol),
    .illegal       (illegal),
    .viol_pulse    (viol_pulse),
    .viol_ch       (viol_ch),
    .illegal_pulse (illegal_pulse)
  );
endmodule

// File: rtl/cml_chk.sv
module cml_chk #(
  parameter int NUM_CH    = 40,
  parameter int NUM_PORTS = 4,
  parameter int CH_W      = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   chan_cfg,
  input logic [NUM_PORTS*3-1:0] mode_in,
  input logic [CH_W-1:0]        chan_id,
  input logic [NUM_PORTS-1:0]   strm_flush,
  input logic [NUM_CH-1:0]      reg_flush,
  input logic [NUM_CH-1:0]      lock_valid,
  input logic [NUM_CH*3-1:0]    lock_mode,
  input logic                   viol_pulse,
  input logic [CH_W-1:0]        viol_ch,
  input logic                   illegal_pulse
);
  // R5
  viol_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> (int'(viol_ch) < NUM_CH));

  // R6
  illegal_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_cfg && mode_in[2:0] > 3'd4) |=> illegal_pulse);

  // R6
  illegal_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_cfg && int'(chan_id) < NUM_CH && mode_in[2:0] > 3'd4) |=> illegal_pulse);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam logic [CH_W-1:0] IDX = CH_W'(c);
    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_valid[c] && !reg_flush[c] && strm_flush == '0)
        |=> (lock_valid[c] && $stable(lock_mode[c*3 +: 3])));
    // R7
    reg_flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_cfg && reg_flush[c] && chan_id != IDX) |=> !lock_valid[c]);
  end
endmodule

bind crypto_mode_lock cml_chk #(.NUM_CH(NUM_CH), .NUM_PORTS(NUM_PORTS), .CH_W(CH_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .chan_cfg      (chan_cfg),
  .mode_in       (mode_in),
  .chan_id       (chan_id),
  .strm_flush    (strm_flush),
  .reg_flush     (reg_flush),
  .lock_valid    (lock_valid),
  .lock_mode     (lock_mode),
  .viol_pulse    (viol_pulse),
  .viol_ch       (viol_ch),
  .illegal_pulse (illegal_pulse)
);

// File: tb/crypto_mode_lock_tb.sv
`timescale 1ns/1ps
module crypto_mode_lock_tb;
  localparam int NCH = 6;
  localparam int NP  = 4;
  localparam int CW  = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            chan_cfg;
  logic [NP*3-1:0] mode_in;
  logic [CW-1:0]   chan_id;
  logic [NP-1:0]   strm_flush;
  logic [NCH-1:0]  reg_flush;
  logic [NCH-1:0]  lock_valid;
  logic [NCH*3-1:0] lock_mode;
  logic            viol_pulse;
  logic [CW-1:0]   viol_ch;
  logic            illegal_pulse;

  int total = 0;
  int bad   = 0;
  string cur_req = "R1";

  int m_v[NCH];
  int m_m[NCH];
  int e_viol, e_ch, e_ill;

  always #2.5 clk = ~clk;

  crypto_mode_lock #(.NUM_CH(NCH), .NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_cfg(chan_cfg), .mode_in(mode_in),
    .chan_id(chan_id), .strm_flush(strm_flush), .reg_flush(reg_flush),
    .lock_valid(lock_valid), .lock_mode(lock_mode), .viol_pulse(viol_pulse),
    .viol_ch(viol_ch), .illegal_pulse(illegal_pulse)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    for (int c = 0; c < NCH; c++) begin
      chk(int'(lock_valid[c]) == m_v[c], $sformatf("valid[%0d]", c), lock_valid[c], m_v[c]);
      if (m_v[c] != 0)
        chk(int'(lock_mode[c*3 +: 3]) == m_m[c], $sformatf("mode[%0d]", c),
            lock_mode[c*3 +: 3], m_m[c]);
    end
    chk(int'(viol_pulse) == e_viol, "viol_pulse", viol_pulse, e_viol);
    if (e_viol != 0) chk(int'(viol_ch) == e_ch, "viol_ch", viol_ch, e_ch);
    chk(int'(illegal_pulse) == e_ill, "illegal_pulse", illegal_pulse, e_ill);
  endtask

  // Behavioural reference: apply current inputs, then advance one clock.
  task automatic cyc();
    int s_en[NCH];
    int s_md[NCH];
    int fl[NCH];
    e_viol = 0; e_ch = 0; e_ill = 0;
    for (int c = 0; c < NCH; c++) begin
      s_en[c] = 0; s_md[c] = 0; fl[c] = reg_flush[c];
      if (!chan_cfg) begin
        if (c < NP) begin
          s_en[c] = 1; s_md[c] = mode_in[c*3 +: 3];
          if (strm_flush[c]) fl[c] = 1;
        end
      end else if (int'(chan_id) == c) begin
        s_en[c] = 1; s_md[c] = mode_in[2:0];
        if (strm_flush[0]) fl[c] = 1;
      end
    end
    for (int c = NCH - 1; c >= 0; c--) begin
      if (fl[c] != 0) m_v[c] = 0;
      if (s_en[c] != 0) begin
        if (s_md[c] > 4) e_ill = 1;
        else if (m_v[c] == 0) begin m_v[c] = 1; m_m[c] = s_md[c]; end
        else if (m_m[c] != s_md[c]) begin e_viol = 1; e_ch = c; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle_in();
    strm_flush = '0; reg_flush = '0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; chan_cfg = 1'b0; mode_in = '0; chan_id = '0;
    strm_flush = '0; reg_flush = '0;
    for (int c = 0; c < NCH; c++) begin m_v[c] = 0; m_m[c] = 0; end
    e_viol = 0; e_ch = 0; e_ill = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    cur_req = "R1"; compare();
    rst_n = 1'b1;

    // fixed-port locking
    cur_req = "R2";
    mode_in = {3'd4, 3'd3, 3'd2, 3'd1};
    cyc(); cyc(); cyc();

    cur_req = "R4";
    mode_in[6 +: 3] = 3'd0; cyc();
    mode_in[6 +: 3] = 3'd2; cyc();

    cur_req = "R5";
    mode_in[3 +: 3] = 3'd0; mode_in[9 +: 3] = 3'd1; cyc();
    mode_in = {3'd4, 3'd3, 3'd2, 3'd1}; cyc();

    cur_req = "R6";
    mode_in[0 +: 3] = 3'd6; cyc();
    mode_in[0 +: 3] = 3'd7; mode_in[3 +: 3] = 3'd5; cyc();
    mode_in = {3'd4, 3'd3, 3'd2, 3'd1}; cyc();

    cur_req = "R8";
    strm_flush = 4'b0010; mode_in[3 +: 3] = 3'd4; cyc();
    idle_in(); cyc();

    cur_req = "R9";
    reg_flush[3] = 1'b1; mode_in[9 +: 3] = 3'd0; cyc();
    idle_in(); cyc();

    cur_req = "R7";
    reg_flush[0] = 1'b1; mode_in[0 +: 3] = 3'd6; cyc();
    idle_in(); mode_in[0 +: 3] = 3'd3; cyc();
    reg_flush[5] = 1'b1; cyc(); idle_in();

    // channelized
    chan_cfg = 1'b1;
    cur_req = "R7";
    chan_id = 3'd7; reg_flush = '1; cyc(); idle_in(); cyc();

    cur_req = "R3";
    for (int c = 0; c < NCH; c++) begin
      chan_id = CW'(c); mode_in[2:0] = 3'(c % 5); cyc();
    end
    for (int c = 0; c < NCH; c++) begin
      chan_id = CW'(c); mode_in[2:0] = 3'(c % 5); cyc();
    end

    cur_req = "R4";
    chan_id = 3'd4; mode_in[2:0] = 3'd1; cyc();
    chan_id = 3'd2; mode_in[2:0] = 3'd0; cyc();

    cur_req = "R8";
    chan_id = 3'd2; strm_flush = 4'b1110; mode_in[2:0] = 3'd0; cyc();
    strm_flush = 4'b0001; chan_id = 3'd5; mode_in[2:0] = 3'd7; cyc();
    idle_in(); chan_id = 3'd1; mode_in[2:0] = 3'd1; cyc();

    cur_req = "R9";
    chan_id = 3'd3; strm_flush = 4'b0001; mode_in[2:0] = 3'd1; cyc();
    idle_in(); cyc();

    cur_req = "R10";
    chan_id = 3'd6; mode_in[2:0] = 3'd0; cyc();
    chan_id = 3'd7; strm_flush = 4'b0001; mode_in[2:0] = 3'd6; cyc();
    idle_in(); cyc();

    cur_req = "R6";
    chan_id = 3'd0; mode_in[2:0] = 3'd5; cyc();

    // random mix in both configurations
    cur_req = "R4";
    for (int n = 0; n < 600; n++) begin
      if (n == 300) chan_cfg = 1'b0;
      mode_in = NP*3'($urandom);
      for (int p = 0; p < NP; p++)
        if (($urandom % 4) != 0) mode_in[p*3 +: 3] = 3'($urandom % 5);
      chan_id = CW'($urandom);
      strm_flush = (($urandom % 8) == 0) ? NP'($urandom) : '0;
      reg_flush  = (($urandom % 8) == 0) ? NCH'($urandom) : '0;
      cyc();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule